// File: doc/BRIEF.md
# OSD Horizontal Raster Timing Generator

This block produces the horizontal timing for an on-screen-display overlay that is 30 character cells wide. Each cell is 12 dots wide. It runs on the pixel clock, and the horizontal sync input is synchronous to that clock. The block watches for the rising edge of the horizontal sync. It then waits a start delay set by a position value, and the delay grows in steps of 6 clocks from a fixed base of 49 clocks. After the delay it raises a display enable for the 360-clock active window. While the window is open it reports which character column and which dot inside that column is being drawn. Downstream font and colour logic uses these indices to fetch and shade each pixel.

A resolution value sets the length of the whole line as 12 clocks per unit. The block counts that length and flags each line end. If no new sync edge arrives, it keeps producing lines with the same timing. A wide-character mode holds every dot for two clocks. In that mode only the even-numbered columns appear in the window, so 15 doubled characters fill the same 360 clocks. A sync edge that arrives early restarts the timing at once. If the window would not fit inside the programmed line, the display enable stays off.

Top module: `osd_htiming`

## Requirements
- R1: While `rst` is high, and after it until the first rising edge of `hsync_in`, `hde`, `col_idx`, `dot_idx` and `line_wrap` are all 0.
- R2: Let D = `hpos`*6 + 49. If the clock edge at cycle k is the first to sample `hsync_in` high after a low sample, `hde` becomes 1 right after clock edge k+D and was 0 right after edge k+D-1.
- R3: With `dbl_wide`=0, `hde` stays high for exactly 360 clocks. At offset t = 0..359 inside the window, `col_idx` = t/12 and `dot_idx` = t mod 12.
- R4: With `dbl_wide`=1, the window is still 360 clocks and each dot index is held for 2 clocks. At offset t, `dot_idx` = (t/2) mod 12 and `col_idx` = 2*((t/2)/12), so only even columns 0..28 appear.
- R5: The line length is L = `hres`*12 clocks. `line_wrap` is high for one cycle right after edge k+L. With no further sync edge, the whole pattern repeats with period L.
- R6: A new sync rising edge restarts the timing even in mid-window. `hde` is 0 after the next clock edge, and all later timing follows R2 from the new edge.
- R7: When D + 360 > L, `hde` stays 0 for the whole line, while `line_wrap` still follows R5.
- R8: Whenever `hde` is 0, `col_idx` and `dot_idx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| hsync_in | input | 1 | Horizontal sync, synchronous to `clk`, rising edge marks the line start |
| hpos | input | 8 | Horizontal position value; start delay is hpos*6+49 clocks |
| hres | input | 8 | Line length in units of 12 clocks |
| dbl_wide | input | 1 | 1 selects double-width characters |
| hde | output | 1 | Horizontal display enable |
| col_idx | output | 5 | Character column being drawn |
| dot_idx | output | 4 | Dot within the character, 0..11 |
| line_wrap | output | 1 | One-cycle pulse at each end of a programmed line |

## Verification
The bench compares every output on every cycle against a model built from the requirements. The first run uses a mid-range position with a long line in normal width, which tests the start delay and the column/dot split. A second run uses the smallest delay in double width, which separates dot holding and even-column stepping from the normal sequence. A boundary pair of resolutions, one just long enough and one just too short, separates a fitting window from a suppressed one. A sync edge sent in mid-window, followed by a long free-running stretch, separates a true restart from a counter that keeps its old phase, and tests line repetition without sync.

// File: rtl/osdh_pkg.sv
package osdh_pkg;

    localparam int CHAR_DOTS   = 12;
    localparam int NUM_COLS    = 30;
    localparam int ACTIVE_DOTS = CHAR_DOTS * NUM_COLS;
    localparam int DLY_STEP    = 6;
    localparam int DLY_BASE    = 49;
    localparam int COL_W       = $clog2(NUM_COLS);
    localparam int DOT_W       = $clog2(CHAR_DOTS);

    typedef logic [COL_W-1:0] col_t;
    typedef logic [DOT_W-1:0] dot_t;

    typedef struct packed {
        logic hde;
        col_t col;
        dot_t dot;
        logic hold;
    } raster_t;

    function automatic int start_delay(input int pos_val);
        return pos_val * DLY_STEP + DLY_BASE;
    endfunction

    function automatic int line_len(input int res_val);
        return res_val * CHAR_DOTS;
    endfunction

endpackage

// File: rtl/osdh_edge.sv
module osdh_edge (
    input  logic clk,
    input  logic rst,
    input  logic hsync_in,
    output logic rise,
    output logic locked
);
    logic hs_q;
    logic lock_q;

    assign rise   = hsync_in & ~hs_q;
    assign locked = lock_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_q   <= 1'b0;
            lock_q <= 1'b0;
        end else begin
            hs_q <= hsync_in;
            if (rise) lock_q <= 1'b1;
        end
    end
endmodule

// File: rtl/osdh_linecnt.sv
module osdh_linecnt #(
    parameter int POS_W = 13
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             rise,
    input  logic             locked,
    input  logic [POS_W-1:0] len,
    output logic [POS_W-1:0] pos,
    output logic             wrap
);
    logic [POS_W-1:0] pos_q;
    logic             wrap_q;
    logic             at_end;

    assign at_end = (pos_q >= len);
    assign pos    = pos_q;
    assign wrap   = wrap_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pos_q  <= '0;
            wrap_q <= 1'b0;
        end else begin
            wrap_q <= locked & at_end;
            if (rise)
                pos_q <= POS_W'(1);
            else if (!locked)
                pos_q <= '0;
            else if (at_end)
                pos_q <= POS_W'(1);
            else
                pos_q <= pos_q + POS_W'(1);
        end
    end
endmodule

// File: rtl/osdh_window.sv
module osdh_window
    import osdh_pkg::*;
#(
    parameter int HPOS_W = 8,
    parameter int HRES_W = 8,
    parameter int POS_W  = 13
) (
    input  logic              locked,
    input  logic [HPOS_W-1:0] hpos,
    input  logic [HRES_W-1:0] hres,
    input  logic [POS_W-1:0]  pos,
    output logic [POS_W-1:0]  len,
    output logic              fits,
    output logic              active
);
    logic [POS_W-1:0] dly;
    logic [POS_W-1:0] win_end;

    always_comb begin
        dly     = POS_W'(start_delay(int'(hpos)));
        len     = POS_W'(line_len(int'(hres)));
        win_end = dly + POS_W'(ACTIVE_DOTS);
        fits    = (win_end <= len);
        active  = locked & fits & (pos >= dly) & (pos < win_end);
    end
endmodule

// File: rtl/osdh_raster.sv
module osdh_raster
    import osdh_pkg::*;
#(
    parameter bit ALLOW_DOUBLE = 1'b1
) (
    input  logic    clk,
    input  logic    rst,
    input  logic    active,
    input  logic    dbl_wide,
    output raster_t ras
);
    raster_t cur;
    raster_t nxt;
    logic    dbl_eff;
    logic    step_dot;
    col_t    col_step;

    generate
        if (ALLOW_DOUBLE) begin : g_dbl
            assign dbl_eff = dbl_wide;
        end else begin : g_single
            assign dbl_eff = 1'b0;
        end
    endgenerate

    assign col_step = dbl_eff ? col_t'(2) : col_t'(1);
    assign step_dot = !(dbl_eff && !cur.hold);

    always_comb begin
        nxt = cur;
        if (!active) begin
            nxt = '0;
        end else if (!cur.hde) begin
            nxt     = '0;
            nxt.hde = 1'b1;
        end else begin
            nxt.hold = dbl_eff & ~cur.hold;
            if (step_dot) begin
                if (cur.dot == dot_t'(CHAR_DOTS - 1)) begin
                    nxt.dot = '0;
                    nxt.col = cur.col + col_step;
                end else begin
                    nxt.dot = cur.dot + dot_t'(1);
                end
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cur <= '0;
        else     cur <= nxt;
    end

    assign ras = cur;
endmodule

// File: rtl/osd_htiming.sv
module osd_htiming
    import osdh_pkg::*;
#(
    parameter int HPOS_W       = 8,
    parameter int HRES_W       = 8,
    parameter bit ALLOW_DOUBLE = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              hsync_in,
    input  logic [HPOS_W-1:0] hpos,
    input  logic [HRES_W-1:0] hres,
    input  logic              dbl_wide,
    output logic              hde,
    output logic [COL_W-1:0]  col_idx,
    output logic [DOT_W-1:0]  dot_idx,
    output logic              line_wrap
);
    localparam int LEN_MAX = (2 ** HRES_W) * CHAR_DOTS;
    localparam int DLY_MAX = (2 ** HPOS_W) * DLY_STEP + DLY_BASE;
    localparam int POS_W   = $clog2(LEN_MAX + DLY_MAX + ACTIVE_DOTS + 1) + 1;

    logic             rise;
    logic             locked;
    logic [POS_W-1:0] pos;
    logic [POS_W-1:0] len;
    logic             fits;
    logic             active;
    raster_t          ras;

    osdh_edge u_edge (
        .clk      (clk),
        .rst      (rst),
        .hsync_in (hsync_in),
        .rise     (rise),
        .locked   (locked)
    );

    osdh_window #(
        .HPOS_W (HPOS_W),
        .HRES_W (HRES_W),
        .POS_W  (POS_W)
    ) u_window (
        .locked (locked),
        .hpos   (hpos),
        .hres   (hres),
        .pos    (pos),
        .len    (len),
        .fits   (fits),
        .active (active)
    );

    osdh_linecnt #(
        .POS_W (POS_W)
    ) u_line (
        .clk    (clk),
        .rst    (rst),
        .rise   (rise),
        .locked (locked),
        .len    (len),
        .pos    (pos),
        .wrap   (line_wrap)
    );

    osdh_raster #(
        .ALLOW_DOUBLE (ALLOW_DOUBLE)
    ) u_raster (
        .clk      (clk),
        .rst      (rst),
        .active   (active),
        .dbl_wide (dbl_wide),
        .ras      (ras)
    );

    assign hde     = ras.hde;
    assign col_idx = ras.col;
    assign dot_idx = ras.dot;
endmodule

// File: rtl/osd_htiming_chk.sv
module osd_htiming_chk
    import osdh_pkg::*;
#(
    parameter int HPOS_W = 8,
    parameter int HRES_W = 8
) (
    input logic              clk,
    input logic              rst,
    input logic              hsync_in,
    input logic [HPOS_W-1:0] hpos,
    input logic [HRES_W-1:0] hres,
    input logic              dbl_wide,
    input logic              hde,
    input logic [COL_W-1:0]  col_idx,
    input logic [DOT_W-1:0]  dot_idx,
    input logic              line_wrap
);
    logic too_long;
    assign too_long = (int'(hpos) * DLY_STEP + DLY_BASE + ACTIVE_DOTS) > (int'(hres) * CHAR_DOTS);

    a_r3_dot_range: assert property (@(posedge clk) disable iff (rst)
        hde |-> (dot_idx < dot_t'(CHAR_DOTS)) && (col_idx < col_t'(NUM_COLS)));

    a_r3_dot_advance: assert property (@(posedge clk) disable iff (rst)
        (hde && $past(hde) && !dbl_wide && !$past(dbl_wide) && $past(dot_idx) != dot_t'(CHAR_DOTS - 1))
        |-> dot_idx == $past(dot_idx) + dot_t'(1));

    a_r4_even_cols: assert property (@(posedge clk) disable iff (rst)
        (hde && dbl_wide && $past(dbl_wide) && $past(hde)) |-> (col_idx[0] == 1'b0));

    a_r6_restart: assert property (@(posedge clk) disable iff (rst)
        (hsync_in && !$past(hsync_in)) |-> ##2 !hde);

    a_r7_suppress: assert property (@(posedge clk) disable iff (rst)
        (too_long && $stable(hpos) && $stable(hres)) |-> !hde);

    a_r8_idle_zero: assert property (@(posedge clk) disable iff (rst)
        !hde |-> (col_idx == '0) && (dot_idx == '0));
endmodule

bind osd_htiming osd_htiming_chk #(
    .HPOS_W (HPOS_W),
    .HRES_W (HRES_W)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .hsync_in  (hsync_in),
    .hpos      (hpos),
    .hres      (hres),
    .dbl_wide  (dbl_wide),
    .hde       (hde),
    .col_idx   (col_idx),
    .dot_idx   (dot_idx),
    .line_wrap (line_wrap)
);

// File: tb/osd_htiming_tb.sv
module osd_htiming_tb;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       hsync_in = 1'b0;
    logic [7:0] hpos = 8'd10;
    logic [7:0] hres = 8'd60;
    logic       dbl_wide = 1'b0;
    logic       hde;
    logic [4:0] col_idx;
    logic [3:0] dot_idx;
    logic       line_wrap;

    int n_cmp = 0;
    int n_bad = 0;

    always #2.5 clk = ~clk;

    osd_htiming u_dut (
        .clk       (clk),
        .rst       (rst),
        .hsync_in  (hsync_in),
        .hpos      (hpos),
        .hres      (hres),
        .dbl_wide  (dbl_wide),
        .hde       (hde),
        .col_idx   (col_idx),
        .dot_idx   (dot_idx),
        .line_wrap (line_wrap)
    );

    task automatic check_val(input string req, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s at %0t: actual=%0d expected=%0d", req, $time, act, exp);
        end
    endtask

    // Pulse the sync, then compare every output for nc cycles against the model.
    task automatic run_line(input int nc, input string req);
        int d, len, p, t, q, e_hde, e_col, e_dot, e_wrap;
        bit fit;
        d   = int'(hpos) * 6 + 49;
        len = int'(hres) * 12;
        fit = (d + 360) <= len;
        @(negedge clk); hsync_in = 1'b1;
        @(posedge clk);
        @(negedge clk); hsync_in = 1'b0;
        for (int c = 1; c <= nc; c++) begin
            @(posedge clk);
            @(negedge clk);
            p      = ((c - 1) % len) + 1;
            e_hde  = (fit && p >= d && p < d + 360) ? 1 : 0;
            t      = p - d;
            e_col  = 0;
            e_dot  = 0;
            if (e_hde == 1) begin
                if (dbl_wide) begin
                    q     = t / 2;
                    e_dot = q % 12;
                    e_col = 2 * (q / 12);
                end else begin
                    e_dot = t % 12;
                    e_col = t / 12;
                end
            end
            e_wrap = (c % len == 0) ? 1 : 0;
            check_val({req, " hde"}, int'(hde), e_hde);
            check_val({req, " col"}, int'(col_idx), e_col);
            check_val({req, " dot"}, int'(dot_idx), e_dot);
            check_val({req, " wrap"}, int'(line_wrap), e_wrap);
        end
    endtask

    task automatic t_reset;
        repeat (3) @(posedge clk);
        @(negedge clk);
        check_val("R1 hde in reset", int'(hde), 0);
        check_val("R1 col in reset", int'(col_idx), 0);
        rst = 1'b0;
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            check_val("R1 hde unlocked", int'(hde), 0);
            check_val("R1 wrap unlocked", int'(line_wrap), 0);
            check_val("R1 dot unlocked", int'(dot_idx), 0);
        end
    endtask

    task automatic t_normal;
        hpos = 8'd10; hres = 8'd60; dbl_wide = 1'b0;
        run_line(2 * 720 + 20, "R2 R3 R5 R8 normal");
    endtask

    task automatic t_double;
        hpos = 8'd0; hres = 8'd70; dbl_wide = 1'b1;
        run_line(2 * 840 + 20, "R4 R5 R8 double");
        dbl_wide = 1'b0;
    endtask

    task automatic t_fit_edge;
        hpos = 8'd1; hres = 8'd35;
        run_line(2 * 420 + 10, "R2 R3 R7 just fits");
        hres = 8'd34;
        run_line(2 * 408 + 10, "R7 R5 too short");
    endtask

    task automatic t_restart;
        hpos = 8'd20; hres = 8'd80;
        run_line(169 + 50, "R6 first line");
        run_line(960 + 169 + 400, "R6 after restart");
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual=running expected=done");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        t_reset();
        t_normal();
        t_double();
        t_fit_edge();
        t_restart();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule